// File: doc/BRIEF.md
# Edge-triggered external interrupt line controller

This block takes forty external request lines and turns selected edges on them into latched pending bits, which then raise pulses on a small set of interrupt outputs. Each line is sampled once per clock. The rising and falling edges are found by comparing the new sample with the previous one. Per-line enable bits choose which edges count, and a per-line mask bit decides whether a qualifying edge is recorded at all. Software can also raise a request on a line, and it clears a request by writing 1 to the pending bit.

The configuration is held in two banks of 32-bit words, one per group of 32 lines. A single-cycle register bus reaches them: a write completes at the clock edge, and read data is returned in the same cycle. Each word keeps only the bits that its lines support. Bits belonging to lines that have no edge logic, and bits with no line behind them, drop any write and read back as zero.

Line 0 and line 1 each drive a dedicated output. Lines 5 to 9 share one merged output. Every output is a one-cycle pulse issued when a pending bit goes from clear to set, so a downstream controller that latches requests keeps its request after software has cleared the bit here.

Top module: `xirq_ctrl`

## Requirements
- R1: The word address is `bus_addr_i` (byte offset divided by 4). Bit 3 picks the bank and bits 2:0 pick the word: 0 interrupt mask, 1 event mask, 2 rising select, 3 falling select, 4 software trigger, 5 pending. Words 6 and 7 read as zero. `bus_rdata_o` shows the addressed word in the same cycle when `bus_sel_i`=1 and `bus_we_i`=0, and is zero otherwise.
- R2: In bank 0, all 32 bits of the interrupt and event masks are writable. The rising select, falling select, software trigger and pending words keep only the bits in 0x007DFFFF, and bits in 0xFF820000 always read 0.
- R3: In bank 1, the two mask words keep only bits 7:0. The rising select, falling select, software trigger and pending words keep only the bits in 0x00000078, and all other bits always read 0.
- R4: A line with only rising select set becomes pending on a 0-to-1 input change. A line with only falling select set becomes pending on a 1-to-0 change. With both set it becomes pending on either change, and with neither set it never does. A change on `line_i` made before clock edge N is readable as pending after edge N+1.
- R5: An edge that arrives while the line's interrupt mask bit is 0 is discarded, and setting the mask afterwards creates no pending bit.
- R6: A write to a software trigger word stores the writable bits as written. Each stored bit that goes from 0 to 1 while the line's mask bit is 1 sets that pending bit at the same clock edge.
- R7: A software trigger bit written from 0 to 1 while its line is masked reads back 1 but sets no pending bit, and unmasking later creates none.
- R8: Writing 1 to a pending bit clears that bit and the matching software trigger bit. Writing 0 leaves both unchanged.
- R9: When a qualifying edge and a write of 1 to the same pending bit fall in the same cycle, the pending bit ends up set.
- R10: `irq_l0_o` and `irq_l1_o` each pulse for exactly one cycle, in the first cycle in which pending bit 0 or 1 (bank 0) reads 1 after being 0. `irq_grp_o` pulses in any cycle in which one of bank 0 pending bits 5 to 9 is newly set. Clearing a bit and re-qualifying an already set bit produce no pulse.
- R11: After reset, all registers, the line sample history and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word address: bit 3 bank, bits 2:0 word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| line_i | input | 40 | External request lines, already synchronous |
| irq_l0_o | output | 1 | Pulse for line 0 |
| irq_l1_o | output | 1 | Pulse for line 1 |
| irq_grp_o | output | 1 | Merged pulse for lines 5 to 9 |

## Verification
The edge detector setting a pending bit and a software write-1-to-clear of the same bit can land in the same cycle. The bench forces this case. It leaves line 0 pending, lets the line fall, raises it again, and issues the clear write exactly one clock after the rise, which is the cycle in which the stored sample differs from the previous one. The pending bit must still read 1 afterwards, and the per-cycle reference model must show no new pulse on `irq_l0_o`, because the bit never went through 0.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned BANK_W    = 1;
  localparam int unsigned ADDR_W    = BANK_W + 3;

  typedef enum logic [2:0] {
    RG_IMASK = 3'd0,
    RG_EMASK = 3'd1,
    RG_RISE  = 3'd2,
    RG_FALL  = 3'd3,
    RG_SWTRG = 3'd4,
    RG_PEND  = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic [WORD_W-1:0] imask;
    logic [WORD_W-1:0] emask;
    logic [WORD_W-1:0] rise;
    logic [WORD_W-1:0] fall;
    logic [WORD_W-1:0] swtrg;
    logic [WORD_W-1:0] pend;
  } bank_wmask_t;

  // configurable vs. direct lines per bank
  localparam bank_wmask_t WM_BANK_A = '{
    imask: 32'hFFFF_FFFF, emask: 32'hFFFF_FFFF,
    rise:  32'h007D_FFFF, fall:  32'h007D_FFFF,
    swtrg: 32'h007D_FFFF, pend:  32'h007D_FFFF};
  localparam bank_wmask_t WM_BANK_B = '{
    imask: 32'h0000_00FF, emask: 32'h0000_00FF,
    rise:  32'h0000_0078, fall:  32'h0000_0078,
    swtrg: 32'h0000_0078, pend:  32'h0000_0078};
endpackage

// File: rtl/xirq_sampler.sv
module xirq_sampler #(
  parameter int unsigned W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] smp_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= '0;
      prev_q <= '0;
    end else begin
      smp_q  <= line_i;
      prev_q <= smp_q;
    end
  end

  assign rise_o = smp_q & ~prev_q;
  assign fall_o = ~smp_q & prev_q;
endmodule

// File: rtl/xirq_bank.sv
module xirq_bank
  import xirq_pkg::*;
#(
  parameter bank_wmask_t WMASK = WM_BANK_A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] rise_i,
  input  logic [WORD_W-1:0] fall_i,
  output logic [WORD_W-1:0] rd_o,
  output logic [WORD_W-1:0] newp_o
);
  logic [WORD_W-1:0] imask_q, emask_q, rise_q, fall_q, swtrg_q, pend_q;
  logic [WORD_W-1:0] sw_up, clr, hit;
  logic              wr_sw, wr_pend;

  assign wr_sw   = we_i && (idx_i == RG_SWTRG);
  assign wr_pend = we_i && (idx_i == RG_PEND);

  always_comb begin
    sw_up = wr_sw   ? (wdata_i & WMASK.swtrg & ~swtrg_q) : '0;
    clr   = wr_pend ? (wdata_i & WMASK.pend) : '0;
    // masked lines drop their edges for good
    hit   = imask_q & ((rise_i & rise_q) | (fall_i & fall_q) | sw_up);
  end

  assign newp_o = hit & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      swtrg_q <= '0;
      pend_q  <= '0;
    end else begin
      pend_q  <= (pend_q & ~clr) | hit;  // set beats clear
      swtrg_q <= wr_sw ? (wdata_i & WMASK.swtrg) : (swtrg_q & ~clr);
      if (we_i) begin
        case (idx_i)
          RG_IMASK: imask_q <= wdata_i & WMASK.imask;
          RG_EMASK: emask_q <= wdata_i & WMASK.emask;
          RG_RISE:  rise_q  <= wdata_i & WMASK.rise;
          RG_FALL:  fall_q  <= wdata_i & WMASK.fall;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx_i)
      RG_IMASK: rd_o = imask_q;
      RG_EMASK: rd_o = emask_q;
      RG_RISE:  rd_o = rise_q;
      RG_FALL:  rd_o = fall_q;
      RG_SWTRG: rd_o = swtrg_q;
      RG_PEND:  rd_o = pend_q;
      default:  rd_o = '0;
    endcase
  end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int unsigned                  NUM_LINES   = 40,
  parameter logic [NUM_BANKS*WORD_W-1:0]  IRQ0_SEL    = 64'h1,
  parameter logic [NUM_BANKS*WORD_W-1:0]  IRQ1_SEL    = 64'h2,
  parameter logic [NUM_BANKS*WORD_W-1:0]  IRQ_GRP_SEL = 64'h3E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic [NUM_LINES-1:0] line_i,
  output logic              irq_l0_o,
  output logic              irq_l1_o,
  output logic              irq_grp_o
);
  localparam int unsigned SPAN = NUM_BANKS * WORD_W;

  logic [NUM_LINES-1:0]              rise, fall;
  logic [SPAN-1:0]                   rise_w, fall_w, newp;
  logic [NUM_BANKS-1:0][WORD_W-1:0]  rd_b;
  logic [BANK_W-1:0]                 bank_sel;

  assign bank_sel = bus_addr_i[ADDR_W-1:3];

  xirq_sampler #(.W(NUM_LINES)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign rise_w = SPAN'(rise);
  assign fall_w = SPAN'(fall);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam bank_wmask_t WM = (b == 0) ? WM_BANK_A : WM_BANK_B;
    logic we_b;
    assign we_b = bus_sel_i && bus_we_i && (bank_sel == BANK_W'(b));

    xirq_bank #(.WMASK(WM)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_b),
      .idx_i   (bus_addr_i[2:0]),
      .wdata_i (bus_wdata_i),
      .rise_i  (rise_w[b*WORD_W +: WORD_W]),
      .fall_i  (fall_w[b*WORD_W +: WORD_W]),
      .rd_o    (rd_b[b]),
      .newp_o  (newp[b*WORD_W +: WORD_W])
    );
  end

  assign bus_rdata_o = (bus_sel_i && !bus_we_i) ? rd_b[bank_sel] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_l0_o  <= 1'b0;
      irq_l1_o  <= 1'b0;
      irq_grp_o <= 1'b0;
    end else begin
      irq_l0_o  <= |(newp & IRQ0_SEL);
      irq_l1_o  <= |(newp & IRQ1_SEL);
      irq_grp_o <= |(newp & IRQ_GRP_SEL);
    end
  end
endmodule

// File: rtl/xirq_chk.sv
module xirq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_sel_i,
  input logic        bus_we_i,
  input logic [3:0]  bus_addr_i,
  input logic [31:0] bus_rdata_o,
  input logic        irq_l0_o,
  input logic        irq_l1_o
);
  AST_L0_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_l0_o |=> !irq_l0_o); // R10
  AST_L1_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_l1_o |=> !irq_l1_o); // R10
  AST_A_RISE_DIRECT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_we_i && bus_addr_i == 4'h2) |-> ((bus_rdata_o & 32'hFF82_0000) == 32'h0)); // R2
  AST_B_PEND_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_we_i && bus_addr_i == 4'hD) |-> ((bus_rdata_o & ~32'h0000_0078) == 32'h0)); // R3
  AST_B_MASK_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_we_i && bus_addr_i == 4'h8) |-> (bus_rdata_o[31:8] == 24'h0)); // R3
endmodule

bind xirq_ctrl xirq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_l0_o    (irq_l0_o),
  .irq_l1_o    (irq_l1_o)
);

// File: tb/sim_xirq_ctrl.sv
module sim_xirq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [39:0] lines = '0;
  logic [31:0] rdata;
  logic        irq0, irq1, irqg;

  int total = 0, bad = 0, grp_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xirq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .line_i(lines), .irq_l0_o(irq0), .irq_l1_o(irq1), .irq_grp_o(irqg)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // writable bits per bank/word, from R2 and R3
  function automatic bit [31:0] wm(int b, int r);
    if (b == 0) return (r < 2) ? 32'hFFFF_FFFF : 32'h007D_FFFF;
    return (r < 2) ? 32'h0000_00FF : 32'h0000_0078;
  endfunction

  // behavioural reference model
  bit [31:0] m_reg [2][6];
  bit [39:0] m_smp, m_prev;
  bit        m_i0, m_i1, m_ig;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_reg[b, r]) m_reg[b][r] = '0;
      m_smp = '0; m_prev = '0; m_i0 = 0; m_i1 = 0; m_ig = 0;
    end else begin
      bit [31:0] nxt [2][6];
      bit [63:0] np;
      bit [31:0] msk;
      bit rs, fs, up, cl, h, wbank;
      int j;
      np = '0;
      for (int b = 0; b < 2; b++) begin
        for (int r = 0; r < 6; r++) nxt[b][r] = m_reg[b][r];
        wbank = sel && we && (int'(addr[3]) == b);
        for (int k = 0; k < 32; k++) begin
          j = b * 32 + k;
          rs = 0; fs = 0;
          if (j < 40) begin
            rs = m_smp[j] && !m_prev[j];
            fs = !m_smp[j] && m_prev[j];
          end
          msk = wm(b, 4);
          up = wbank && addr[2:0] == 3'd4 && wdata[k] && msk[k] && !m_reg[b][4][k];
          msk = wm(b, 5);
          cl = wbank && addr[2:0] == 3'd5 && wdata[k] && msk[k];
          h  = m_reg[b][0][k] && ((rs && m_reg[b][2][k]) || (fs && m_reg[b][3][k]) || up);
          if (h && !m_reg[b][5][k]) np[j] = 1;
          if (h) nxt[b][5][k] = 1;
          else if (cl) nxt[b][5][k] = 0;
          msk = wm(b, 4);
          if (wbank && addr[2:0] == 3'd4) nxt[b][4][k] = wdata[k] && msk[k];
          else if (cl) nxt[b][4][k] = 0;
        end
        for (int r = 0; r < 4; r++)
          if (wbank && int'(addr[2:0]) == r) nxt[b][r] = wdata & wm(b, r);
      end
      m_reg  = nxt;
      m_i0   = np[0];
      m_i1   = np[1];
      m_ig   = |np[9:5];
      m_prev = m_smp;
      m_smp  = lines;
    end
  end

  function automatic logic [31:0] exp_rd();
    if (sel && !we && addr[2:0] < 3'd6) return m_reg[addr[3]][addr[2:0]];
    return '0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rdata == exp_rd(), "R1 per-cycle read data", rdata, exp_rd());
      chk(irq0 == m_i0, "R10 per-cycle irq_l0", 32'(irq0), 32'(m_i0));
      chk(irq1 == m_i1, "R10 per-cycle irq_l1", 32'(irq1), 32'(m_i1));
      chk(irqg == m_ig, "R10 per-cycle irq_grp", 32'(irqg), 32'(m_ig));
      if (irqg) grp_cnt++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    sel = 1; we = 1; addr = a; wdata = d;
    tick(1);
    sel = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    sel = 1; we = 0; addr = a;
    @(negedge clk);
    chk(rdata == exp, req, rdata, exp);
    tick(1);
    sel = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick(1);
    // R11 reset state
    for (int a = 0; a < 14; a++) if (a != 6 && a != 7) rd(4'(a), 32'h0, "R11 reset value");
    chk({irq0, irq1, irqg} == 3'b000, "R11 outputs idle", 32'({irq0, irq1, irqg}), 32'h0);

    // R2 bank 0 writable bits
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, 32'hFFFF_FFFF, "R2 imask full");
    wr(4'h1, 32'hFFFF_FFFF); rd(4'h1, 32'hFFFF_FFFF, "R2 emask full");
    wr(4'h2, 32'hFFFF_FFFF); rd(4'h2, 32'h007D_FFFF, "R2 rise select");
    wr(4'h3, 32'hFF82_0000); rd(4'h3, 32'h0, "R2 fall direct bits");
    wr(4'h0, 32'h0); wr(4'h1, 32'h0); wr(4'h2, 32'h0);
    wr(4'h4, 32'hFF82_0000); rd(4'h4, 32'h0, "R2 swtrg direct bits");
    wr(4'h5, 32'hFF82_0000); rd(4'h5, 32'h0, "R2 pend direct bits");

    // R3 bank 1 writable bits
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, 32'h0000_00FF, "R3 imask");
    wr(4'h9, 32'hFFFF_FFFF); rd(4'h9, 32'h0000_00FF, "R3 emask");
    wr(4'hA, 32'hFFFF_FFFF); rd(4'hA, 32'h0000_0078, "R3 rise select");
    wr(4'hB, 32'h0000_0087); rd(4'hB, 32'h0, "R3 fall reserved");
    wr(4'hC, 32'hFFFF_FF87); rd(4'hC, 32'h0, "R3 swtrg reserved");
    rd(4'hD, 32'h0, "R3 pend untouched");
    wr(4'h8, 32'h0); wr(4'h9, 32'h0); wr(4'hA, 32'h0);

    // R1 holes
    rd(4'h6, 32'h0, "R1 word 6 zero");
    rd(4'hF, 32'h0, "R1 word 15 zero");

    // R6 software trigger, unmasked
    wr(4'h0, 32'h1); wr(4'h4, 32'h0); wr(4'h4, 32'h1);
    chk(irq0 == 1'b1, "R10 irq_l0 pulse on sw trigger", 32'(irq0), 32'h1);
    rd(4'h4, 32'h1, "R6 swtrg readback");
    rd(4'h5, 32'h1, "R6 pending set");
    chk(irq0 == 1'b0, "R10 irq_l0 single cycle", 32'(irq0), 32'h0);
    // R8 clear semantics
    wr(4'h5, 32'h0); rd(4'h5, 32'h1, "R8 write 0 keeps pending");
    wr(4'h5, 32'h1); rd(4'h5, 32'h0, "R8 write 1 clears pending");
    rd(4'h4, 32'h0, "R8 clear drops swtrg");
    chk(irq0 == 1'b0, "R10 no pulse on clear", 32'(irq0), 32'h0);

    // R7 software trigger while masked
    wr(4'h0, 32'h0); wr(4'h4, 32'h1);
    rd(4'h4, 32'h1, "R7 swtrg reads 1 when masked");
    rd(4'h5, 32'h0, "R7 no pending when masked");
    wr(4'h0, 32'h1); tick(2);
    rd(4'h5, 32'h0, "R7 unmask creates nothing");
    wr(4'h4, 32'h0);

    // bank 1 software line 35
    wr(4'h8, 32'h8); wr(4'hC, 32'h8);
    rd(4'hD, 32'h8, "R6 bank1 line 35 pending");
    wr(4'hD, 32'h8); rd(4'hD, 32'h0, "R8 bank1 clear");
    rd(4'hC, 32'h0, "R8 bank1 swtrg cleared");

    // R4 edge selection on line 0
    wr(4'h0, 32'h1); wr(4'h2, 32'h1); wr(4'h3, 32'h0);
    lines[0] = 1; tick(3); rd(4'h5, 32'h1, "R4 rising only, rise");
    wr(4'h5, 32'h1);
    lines[0] = 0; tick(3); rd(4'h5, 32'h0, "R4 rising only, fall ignored");
    wr(4'h2, 32'h0); wr(4'h3, 32'h1);
    lines[0] = 1; tick(3); rd(4'h5, 32'h0, "R4 falling only, rise ignored");
    lines[0] = 0; tick(3); rd(4'h5, 32'h1, "R4 falling only, fall");
    wr(4'h5, 32'h1);
    wr(4'h2, 32'h1);
    lines[0] = 1; tick(3); rd(4'h5, 32'h1, "R4 both, rise");
    wr(4'h5, 32'h1);
    lines[0] = 0; tick(3); rd(4'h5, 32'h1, "R4 both, fall");
    wr(4'h5, 32'h1);
    wr(4'h2, 32'h0); wr(4'h3, 32'h0);
    lines[0] = 1; tick(3); rd(4'h5, 32'h0, "R4 none, rise");
    lines[0] = 0; tick(3); rd(4'h5, 32'h0, "R4 none, fall");

    // R9 edge and clear in the same cycle
    wr(4'h2, 32'h1);
    lines[0] = 1; tick(3);
    lines[0] = 0; tick(3);
    lines[0] = 1; tick(1);
    wr(4'h5, 32'h1);
    rd(4'h5, 32'h1, "R9 set wins over clear");
    wr(4'h5, 32'h1); rd(4'h5, 32'h0, "R8 final clear");

    // R5 masked edge discarded
    wr(4'h0, 32'h0); wr(4'h2, 32'h2);
    lines[1] = 1; tick(3);
    rd(4'h5, 32'h0, "R5 masked edge dropped");
    wr(4'h0, 32'h2); tick(2);
    rd(4'h5, 32'h0, "R5 unmask creates nothing");
    chk(irq1 == 1'b0, "R5 no irq_l1", 32'(irq1), 32'h0);

    // R10 merged output for lines 5..9
    wr(4'h0, 32'h3E0); wr(4'h2, 32'h3E0);
    grp_cnt = 0;
    for (int i = 5; i < 10; i++) begin
      lines[i] = 1; tick(3);
      rd(4'h5, 32'h1 << i, "R10 group line pending");
      wr(4'h5, 32'h1 << i);
      rd(4'h5, 32'h0, "R8 group clear");
    end
    chk(grp_cnt == 5, "R10 group pulse count", 32'(grp_cnt), 32'd5);

    tick(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule